// File: doc/BRIEF.md
# Three-Bus Single-Cycle Datapath

This block is the execution core of a simple processor. It holds a register file of thirty-two 32-bit registers, two operand buses (X and Y) and one result bus (Z). Every cycle the two read ports place the registers selected by the control word onto X and Y. The adder/subtractor, the bitwise logic unit and the barrel shifter all receive both buses at the same time. The control word picks at most one unit to drive Z. When the register write enable is set, Z is stored into the destination register on the next rising clock edge.

The block has no instruction fetch or decode. A sequencer outside it supplies the register selects, the write enable and the per-unit controls directly, once per cycle. The register file has no external write-data path, so every value comes from Z. Constants are built from the zero register and the units, for example an all-ones truth table, then subtract, add and shift. Register 0 always reads as zero.

Top module: `tri_bus_datapath`

## Requirements
- R1: A synchronous active-low reset clears every register, so in the cycle after a clock edge taken with `rst_n` low, every read port returns 0.
- R2: Register 0 always reads as 0, and a write addressed to register 0 leaves every register unchanged.
- R3: `x_bus` shows the register selected by `rd_sel_x` and `y_bus` the one selected by `rd_sel_y`, both combinationally. With `wr_en` high, `z_bus` is stored into register `wr_sel` at the rising edge and can be read from the next cycle. A read of that register in the writing cycle returns the old value.
- R4: With `wr_en` low no register changes, whatever the unit controls are.
- R5: The adder drives X+Y when `add_sub` is 0 and X−Y when it is 1, modulo 2^32 (the carry-out is dropped).
- R6: Bit i of the logic unit's result is `logic_tt[{x[i],y[i]}]`. So 4'b0110 gives XOR, 4'b1000 gives AND and 4'b1111 gives all ones.
- R7: The shift amount is `y_bus[5:0]` read as a two's complement number from −32 to +31. A positive amount shifts X right and a negative amount shifts X left, by the magnitude.
- R8: `shift_kind` selects the shift type:
  - 2'b00 is logical (zero fill).
  - 2'b01 is arithmetic: a right shift fills with the sign bit and a left shift is the same as logical.
  - 2'b10 is rotate.
  - 2'b11 behaves as logical.
- R9: `z_bus` equals the output of the single unit whose drive enable is high, and is 0 when no enable is high. At most one of `add_drive`, `logic_drive` and `shift_drive` may be high in a cycle.
- R10: An amount code of 6'b100000 (−32) shifts left by the full width. The result is 0 for the logical and arithmetic kinds and X unchanged for rotate. A right arithmetic shift by 31 gives all copies of the sign bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; registers update on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_sel_x | input | 5 | Register selected onto X bus |
| rd_sel_y | input | 5 | Register selected onto Y bus |
| wr_sel | input | 5 | Destination register for Z |
| wr_en | input | 1 | Register write enable |
| add_drive | input | 1 | Adder/subtractor drives Z |
| add_sub | input | 1 | 0: add, 1: subtract |
| logic_drive | input | 1 | Logic unit drives Z |
| logic_tt | input | 4 | Truth table indexed by {x bit, y bit} |
| shift_drive | input | 1 | Shifter drives Z |
| shift_kind | input | 2 | 00 logical, 01 arithmetic, 10 rotate, 11 logical |
| x_bus | output | 32 | Operand bus X (read port 1) |
| y_bus | output | 32 | Operand bus Y (read port 2) |
| z_bus | output | 32 | Result bus, written back under `wr_en` |

## Verification
The bench builds the block with its default values, a 32-bit width and 32 registers. With these values the 6-bit shift amount reaches its −32 corner, where the shift spans the full word. Every one of the 31 writable registers and the zero register can be reached from the random control words. A directed prologue builds constants through the units alone, then a long random run compares X, Y and Z each cycle against a per-bit behavioural model.

// File: rtl/dp_pkg.sv
// Package dp_pkg: shared encodings for the three-bus datapath.
// Assumes: shift kind is a 2-bit field supplied by the external sequencer.
package dp_pkg;

    typedef enum logic [1:0] {
        SHK_LOGICAL = 2'b00,
        SHK_ARITH   = 2'b01,
        SHK_ROTATE  = 2'b10,
        SHK_SPARE   = 2'b11
    } shift_kind_e;

endpackage

// File: rtl/dp_regfile.sv
// Module dp_regfile: NUM_REGS x DATA_W register file with two combinational
// read ports and one write port that is clocked on the rising edge.
// Assumes: entry 0 is a constant zero, so a write to it is dropped.
// A same-cycle read of the register being written returns the old value.
module dp_regfile #(
    parameter  int DATA_W   = 32,
    parameter  int NUM_REGS = 32,
    localparam int ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ra_x,
    input  logic [ADDR_W-1:0] ra_y,
    input  logic [ADDR_W-1:0] wa,
    input  logic              we,
    input  logic [DATA_W-1:0] wd,
    output logic [DATA_W-1:0] rd_x,
    output logic [DATA_W-1:0] rd_y
);

    logic [DATA_W-1:0] entry [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
        if (i == 0) begin : g_zero
            // constant zero register
            assign entry[i] = '0;
        end else begin : g_reg
            logic [DATA_W-1:0] q;
            // store write data when this entry is addressed, clear on reset
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (we && (wa == ADDR_W'(i))) begin
                    q <= wd;
                end
            end
            assign entry[i] = q;
        end
    end

    // read multiplexers for the two operand buses
    assign rd_x = entry[ra_x];
    assign rd_y = entry[ra_y];

endmodule

// File: rtl/dp_addsub.sv
// Module dp_addsub: two's complement adder/subtractor, carry-out discarded.
// Assumes: sub = 0 adds, sub = 1 subtracts b from a.
module dp_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] y
);

    logic [DATA_W-1:0] b_eff;

    // invert the second operand and inject a carry for subtraction
    always_comb begin
        b_eff = sub ? ~b : b;
        y     = a + b_eff + DATA_W'(sub);
    end

endmodule

// File: rtl/dp_logic.sv
// Module dp_logic: bitwise unit that applies any two-input boolean function,
// given as a 4-bit truth table, to each bit pair of the operands.
// Assumes: table index is {a bit, b bit}.
module dp_logic #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [3:0]        tt,
    output logic [DATA_W-1:0] y
);

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        // per-bit truth table lookup
        assign y[i] = tt[{a[i], b[i]}];
    end

endmodule

// File: rtl/dp_shifter.sv
// Module dp_shifter: barrel shifter with a signed amount. A positive amount
// shifts right and a negative amount shifts left.
// Assumes: amt is two's complement with SH_W = log2(DATA_W)+1 bits.
module dp_shifter
    import dp_pkg::*;
#(
    parameter  int DATA_W = 32,
    localparam int SH_W   = $clog2(DATA_W) + 1
) (
    input  logic [DATA_W-1:0] a,
    input  logic [SH_W-1:0]   amt,
    input  logic [1:0]        kind,
    output logic [DATA_W-1:0] y
);

    localparam logic [31:0] WIDTH = 32'(DATA_W);

    logic              go_left;
    logic [SH_W-1:0]   mag;
    logic [31:0]       n;
    logic [31:0]       rn;
    logic [31:0]       back;
    shift_kind_e       k;

    // decode direction and magnitude from the signed amount
    always_comb begin
        go_left = amt[SH_W-1];
        mag     = go_left ? (~amt + 1'b1) : amt;
        n       = 32'(mag);
        rn      = n % WIDTH;
        back    = (WIDTH - rn) % WIDTH;
        k       = shift_kind_e'(kind);
    end

    // select the shift result for the requested direction and kind
    always_comb begin
        if (go_left) begin
            case (k)
                SHK_ROTATE: y = (a << rn) | (a >> back);
                default:    y = a << n;
            endcase
        end else begin
            case (k)
                SHK_ARITH:  y = DATA_W'($signed(a) >>> n);
                SHK_ROTATE: y = (a >> rn) | (a << back);
                default:    y = a >> n;
            endcase
        end
    end

endmodule

// File: rtl/tri_bus_datapath.sv
// Module tri_bus_datapath: single-cycle datapath. The register file read
// ports drive operand buses X and Y into every functional unit. The enabled
// unit drives result bus Z, which is written back under wr_en at the edge.
// Assumes: at most one drive enable per cycle; with none, Z is zero.
module tri_bus_datapath
    import dp_pkg::*;
#(
    parameter  int DATA_W   = 32,
    parameter  int NUM_REGS = 32,
    localparam int ADDR_W   = $clog2(NUM_REGS),
    localparam int SH_W     = $clog2(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_sel_x,
    input  logic [ADDR_W-1:0] rd_sel_y,
    input  logic [ADDR_W-1:0] wr_sel,
    input  logic              wr_en,
    input  logic              add_drive,
    input  logic              add_sub,
    input  logic              logic_drive,
    input  logic [3:0]        logic_tt,
    input  logic              shift_drive,
    input  logic [1:0]        shift_kind,
    output logic [DATA_W-1:0] x_bus,
    output logic [DATA_W-1:0] y_bus,
    output logic [DATA_W-1:0] z_bus
);

    logic [DATA_W-1:0] add_res;
    logic [DATA_W-1:0] log_res;
    logic [DATA_W-1:0] sh_res;

    dp_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rf (
        .clk  (clk),
        .rst_n(rst_n),
        .ra_x (rd_sel_x),
        .ra_y (rd_sel_y),
        .wa   (wr_sel),
        .we   (wr_en),
        .wd   (z_bus),
        .rd_x (x_bus),
        .rd_y (y_bus)
    );

    dp_addsub #(.DATA_W(DATA_W)) u_add (
        .a  (x_bus),
        .b  (y_bus),
        .sub(add_sub),
        .y  (add_res)
    );

    dp_logic #(.DATA_W(DATA_W)) u_log (
        .a (x_bus),
        .b (y_bus),
        .tt(logic_tt),
        .y (log_res)
    );

    dp_shifter #(.DATA_W(DATA_W)) u_sh (
        .a   (x_bus),
        .amt (y_bus[SH_W-1:0]),
        .kind(shift_kind),
        .y   (sh_res)
    );

    // AND-OR result bus: each unit gated by its own drive enable
    always_comb begin
        z_bus = ({DATA_W{add_drive}}   & add_res)
              | ({DATA_W{logic_drive}} & log_res)
              | ({DATA_W{shift_drive}} & sh_res);
    end

endmodule

// File: rtl/dp_checker.sv
// Module dp_checker: properties of tri_bus_datapath, attached by bind.
// Assumes: it observes only the ports of the datapath.
module dp_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] rd_sel_x,
    input logic [ADDR_W-1:0] wr_sel,
    input logic              wr_en,
    input logic              add_drive,
    input logic              add_sub,
    input logic              logic_drive,
    input logic [3:0]        logic_tt,
    input logic              shift_drive,
    input logic [DATA_W-1:0] x_bus,
    input logic [DATA_W-1:0] y_bus,
    input logic [DATA_W-1:0] z_bus
);

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (x_bus == '0 && y_bus == '0));

    p_zero_reg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel_x == '0) |-> (x_bus == '0));

    p_write_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel != '0) |=>
            ((rd_sel_x != $past(wr_sel)) || (x_bus == $past(z_bus))));

    p_hold_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((rd_sel_x != $past(rd_sel_x)) || $stable(x_bus)));

    p_subtract_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (add_drive && add_sub && !logic_drive && !shift_drive) |->
            (z_bus == x_bus - y_bus));

    p_xor_table_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (logic_drive && logic_tt == 4'b0110 && !add_drive && !shift_drive) |->
            (z_bus == (x_bus ^ y_bus)));

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!add_drive && !logic_drive && !shift_drive) |-> (z_bus == '0));

    p_one_driver_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({add_drive, logic_drive, shift_drive}));

endmodule

bind tri_bus_datapath dp_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_sel_x   (rd_sel_x),
    .wr_sel     (wr_sel),
    .wr_en      (wr_en),
    .add_drive  (add_drive),
    .add_sub    (add_sub),
    .logic_drive(logic_drive),
    .logic_tt   (logic_tt),
    .shift_drive(shift_drive),
    .x_bus      (x_bus),
    .y_bus      (y_bus),
    .z_bus      (z_bus)
);

// File: tb/sim_tri_bus_datapath.sv
// Bench sim_tri_bus_datapath: drives control words on the falling edge.
// It compares X, Y and Z against a behavioural model before each rising edge.
module sim_tri_bus_datapath;

    localparam int CLK_PERIOD = 10;
    localparam int W = 32;
    localparam int R = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    rsx = '0, rsy = '0, ws = '0;
    logic          we = 1'b0, ad = 1'b0, asb = 1'b0, ld = 1'b0, sd = 1'b0;
    logic [3:0]    tt = '0;
    logic [1:0]    sk = '0;
    logic [W-1:0]  xb, yb, zb;

    logic [W-1:0]  mdl [R];
    int            n_vec = 0;
    int            n_bad = 0;
    bit            finished = 1'b0;

    tri_bus_datapath #(.DATA_W(W), .NUM_REGS(R)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_sel_x(rsx), .rd_sel_y(rsy),
        .wr_sel(ws), .wr_en(we), .add_drive(ad), .add_sub(asb),
        .logic_drive(ld), .logic_tt(tt), .shift_drive(sd),
        .shift_kind(sk), .x_bus(xb), .y_bus(yb), .z_bus(zb)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [W-1:0] ref_shift(input logic [W-1:0] v,
                                               input logic [W-1:0] amt_word,
                                               input logic [1:0]   kind);
        int a;
        logic [W-1:0] r;
        a = int'(amt_word[5:0]);
        if (a >= 32) a = a - 64;
        r = v;
        if (a > 0) begin
            for (int k = 0; k < a; k++) begin
                if (kind == 2'b01)      r = {r[W-1], r[W-1:1]};
                else if (kind == 2'b10) r = {r[0], r[W-1:1]};
                else                    r = {1'b0, r[W-1:1]};
            end
        end else if (a < 0) begin
            for (int k = 0; k < -a; k++) begin
                if (kind == 2'b10) r = {r[W-2:0], r[W-1]};
                else               r = {r[W-2:0], 1'b0};
            end
        end
        return r;
    endfunction

    function automatic logic [W-1:0] ref_logic(input logic [W-1:0] a,
                                               input logic [W-1:0] b,
                                               input logic [3:0]   f);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            int idx;
            idx  = (a[i] ? 2 : 0) + (b[i] ? 1 : 0);
            r[i] = f[idx];
        end
        return r;
    endfunction

    task automatic compare(input string tag, input string what,
                           input logic [W-1:0] act, input logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // one cycle: drive on the falling edge, check, then update the model
    task automatic step(input bit rst, input int x, input int y, input int w,
                        input bit wen, input int unit, input bit sb,
                        input logic [3:0] f, input logic [1:0] kind,
                        input string tag);
        logic [W-1:0] ex, ey, ez;
        @(negedge clk);
        rst_n = ~rst;
        rsx = 5'(x); rsy = 5'(y); ws = 5'(w); we = wen;
        ad = (unit == 1); ld = (unit == 2); sd = (unit == 3);
        asb = sb; tt = f; sk = kind;
        #1;
        ex = mdl[x]; ey = mdl[y];
        case (unit)
            1:       ez = sb ? ex - ey : ex + ey;
            2:       ez = ref_logic(ex, ey, f);
            3:       ez = ref_shift(ex, ey, kind);
            default: ez = '0;
        endcase
        if (!rst) begin
            compare(tag, "x_bus", xb, ex);
            compare(tag, "y_bus", yb, ey);
            compare(tag, "z_bus", zb, ez);
        end
        @(posedge clk);
        if (rst) begin
            foreach (mdl[i]) mdl[i] = '0;
        end else if (wen && w != 0) begin
            mdl[w] = ez;
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        foreach (mdl[i]) mdl[i] = '0;
        step(1, 0, 0, 0, 0, 0, 0, 4'h0, 2'b00, "R1");
        step(1, 0, 0, 0, 0, 0, 0, 4'h0, 2'b00, "R1");
        // reset state visible on both read ports
        step(0, 1, 31, 0, 0, 0, 0, 4'h0, 2'b00, "R1");
        // r1 = all ones from the truth table
        step(0, 0, 0, 1, 1, 2, 0, 4'b1111, 2'b00, "R6");
        step(0, 0, 1, 2, 1, 1, 1, 4'h0, 2'b00, "R5");   // r2 = 0 - (-1) = 1
        step(0, 2, 2, 3, 1, 1, 0, 4'h0, 2'b00, "R5");   // r3 = 2
        step(0, 1, 2, 4, 1, 1, 0, 4'h0, 2'b00, "R5");   // r4 = wrap to 0
        // write to register 0 is dropped
        step(0, 0, 0, 0, 1, 2, 0, 4'b1111, 2'b00, "R2");
        step(0, 0, 0, 0, 0, 0, 0, 4'h0, 2'b00, "R2");
        // no write enable: r5 stays zero
        step(0, 0, 0, 5, 0, 2, 0, 4'b1111, 2'b00, "R4");
        step(0, 5, 5, 0, 0, 0, 0, 4'h0, 2'b00, "R4");
        // same-cycle read of written register returns old value
        step(0, 3, 3, 3, 1, 1, 0, 4'h0, 2'b00, "R3");
        step(0, 3, 0, 0, 0, 0, 0, 4'h0, 2'b00, "R3");
        // build 32 in r6 and 31 in r7
        step(0, 2, 2, 6, 1, 1, 0, 4'h0, 2'b00, "R5");
        step(0, 6, 6, 6, 1, 1, 0, 4'h0, 2'b00, "R5");
        step(0, 6, 6, 6, 1, 1, 0, 4'h0, 2'b00, "R5");
        step(0, 6, 6, 6, 1, 1, 0, 4'h0, 2'b00, "R5");
        step(0, 6, 6, 6, 1, 1, 0, 4'h0, 2'b00, "R5");
        step(0, 6, 2, 7, 1, 1, 1, 4'h0, 2'b00, "R5");
        // shifts
        step(0, 2, 2, 8, 1, 3, 0, 4'h0, 2'b10, "R8");   // rotate 1 right: sign bit
        step(0, 8, 7, 9, 1, 3, 0, 4'h0, 2'b01, "R10");  // arith right 31
        step(0, 8, 7, 9, 1, 3, 0, 4'h0, 2'b00, "R7");   // logical right 31
        step(0, 8, 6, 9, 1, 3, 0, 4'h0, 2'b10, "R10");  // rotate left 32
        step(0, 8, 6, 9, 1, 3, 0, 4'h0, 2'b00, "R10");  // logical left 32
        step(0, 1, 6, 9, 1, 3, 0, 4'h0, 2'b01, "R10");  // arith left 32
        step(0, 8, 2, 9, 1, 3, 0, 4'h0, 2'b11, "R8");   // spare kind as logical
        step(0, 2, 1, 9, 1, 3, 0, 4'h0, 2'b01, "R8");   // arith left 1
        step(0, 1, 2, 9, 1, 3, 0, 4'h0, 2'b01, "R8");   // arith right keeps sign
        step(0, 9, 9, 0, 0, 0, 0, 4'h0, 2'b00, "R7");
        // logic functions and idle bus
        step(0, 8, 1, 10, 1, 2, 0, 4'b0110, 2'b00, "R6");
        step(0, 10, 7, 11, 1, 2, 0, 4'b1000, 2'b00, "R6");
        step(0, 10, 7, 12, 1, 0, 0, 4'h0, 2'b00, "R9");
        step(0, 12, 11, 0, 0, 0, 0, 4'h0, 2'b00, "R9");
        // mid-run reset clears written registers
        step(1, 0, 0, 0, 0, 0, 0, 4'h0, 2'b00, "R1");
        step(0, 1, 10, 0, 0, 0, 0, 4'h0, 2'b00, "R1");
        step(0, 7, 8, 0, 0, 0, 0, 4'h0, 2'b00, "R1");
        // seed constants again, then a random run
        step(0, 0, 0, 1, 1, 2, 0, 4'b1111, 2'b00, "R6");
        step(0, 0, 1, 2, 1, 1, 1, 4'h0, 2'b00, "R5");
        for (int c = 0; c < 4000; c++) begin
            int    u;
            string tg;
            u = int'($urandom_range(0, 3));
            tg = (u == 1) ? "R5" : (u == 2) ? "R6" : (u == 3) ? "R7" : "R9";
            step(0, int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
                 int'($urandom_range(0, 31)), ($urandom_range(0, 3) != 0), u,
                 1'($urandom), 4'($urandom), 2'($urandom), tg);
        end
        finished = 1'b1;
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

endmodule